// File: doc/BRIEF.md
# Four-Channel Note Programming Front End

This block turns parallel note commands into per-channel settings for a bank of four square-wave tone channels. Each command carries a 4-bit note code, a 2-bit octave code, a 2-bit level (magnitude) code and a 2-bit channel select. A write strobe commits the command. Inputs and outputs share one clock, nominally 120 kHz.

A fixed semitone table turns the note code into an 8-bit divider count. Each count equals round(120000 / (2 × f)), where f is the note's pitch in the top octave (C at about 523 Hz up to B at about 988 Hz, with A at 880 Hz). The tone channels downstream reach lower octaves by clock selection, so one table serves all three octaves. On the rising edge of the strobe, the count, octave and level are stored into the addressed channel only. That channel also gets a one-cycle update pulse, which tells it to restart its divider with the new count.

Top module: `tone_prog_top`

## Requirements
- R1: While reset is held, and after it is released until the first write, every channel shows count 0, octave 0, level 0 (off) and no update pulse.
- R2: A valid note code selects these counts: 0→61, 1→64, 2→68, 3→72, 4→77, 5→81, 6→86, 7→91, 8→96, 9→102, 10→108, 11→115. These are B, A#, A, G#, G, F#, F, E, D#, D, C# and C, descending in pitch.
- R3: Channel select 0, 1, 2 and 3 addresses output lanes 0, 1, 2 and 3, which are bit slices [8i+7:8i] of `count_o` and [2i+1:2i] of `oct_o` and `lvl_o`. A write changes only the addressed lane.
- R4: A write stores the octave and level codes present on the inputs in the cycle the strobe rises, together with the count.
- R5: A write whose note code is 12 to 15 is ignored. No lane changes and no update pulse appears.
- R6: The strobe acts on its rising edge. A strobe held high for several cycles makes exactly one update, even if the other inputs change while it is held.
- R7: The new values and a one-cycle update pulse on the addressed lane of `upd_o` appear together, one clock after the clock edge that first samples the strobe high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| note_i | input | 4 | Note code |
| oct_i | input | 2 | Octave code |
| lvl_i | input | 2 | Level code, 0 = off |
| chan_sel_i | input | 2 | Target channel |
| wr_i | input | 1 | Write strobe, acts on its rising edge |
| count_o | output | 32 | Four 8-bit divider counts |
| oct_o | output | 8 | Four 2-bit octave codes |
| lvl_o | output | 8 | Four 2-bit level codes |
| upd_o | output | 4 | One-cycle restart pulse per channel |

## Verification
Two events can fall in the same cycle: a strobe rising edge and an invalid note code. A correct design must then refuse both the table lookup and the edge detector's trigger. The bench raises the strobe together with each of the codes 12 to 15, and it also holds the strobe high while it changes the channel select and the note. It judges both cases by the absence of any update pulse, and by the stored lanes, which must match the model before and after.

// File: rtl/tone_prog_pkg.sv
package tone_prog_pkg;

    localparam int NUM_CH    = 4;
    localparam int CNT_W     = 8;
    localparam int NOTE_W    = 4;
    localparam int OCT_W     = 2;
    localparam int LVL_W     = 2;
    localparam int SEL_W     = $clog2(NUM_CH);
    localparam int NUM_NOTES = 12;

    typedef enum logic [LVL_W-1:0] {
        LVL_OFF  = 2'b00,
        LVL_LOW  = 2'b01,
        LVL_MID  = 2'b10,
        LVL_HIGH = 2'b11
    } level_e;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [OCT_W-1:0] octave;
        level_e           level;
    } chan_cfg_t;

    typedef struct packed {
        logic             valid;
        logic [CNT_W-1:0] count;
    } lut_out_t;

    // Divider half-period counts for the top octave at a 120 kHz clock,
    // ordered from highest pitch (code 0) downward.
    function automatic lut_out_t note_to_count(input logic [NOTE_W-1:0] code);
        lut_out_t r;
        r.valid = (int'(code) < NUM_NOTES);
        case (code)
            4'd0:    r.count = 8'd61;
            4'd1:    r.count = 8'd64;
            4'd2:    r.count = 8'd68;
            4'd3:    r.count = 8'd72;
            4'd4:    r.count = 8'd77;
            4'd5:    r.count = 8'd81;
            4'd6:    r.count = 8'd86;
            4'd7:    r.count = 8'd91;
            4'd8:    r.count = 8'd96;
            4'd9:    r.count = 8'd102;
            4'd10:   r.count = 8'd108;
            4'd11:   r.count = 8'd115;
            default: r.count = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tone_note_lut.sv
module tone_note_lut
    import tone_prog_pkg::*;
(
    input  logic [NOTE_W-1:0] note_i,
    output lut_out_t          lut_o
);

    always_comb lut_o = note_to_count(note_i);

endmodule

// File: rtl/tone_wr_edge.sv
module tone_wr_edge (
    input  logic clk,
    input  logic rst,
    input  logic wr_i,
    output logic fire_o
);

    logic wr_q;

    always_ff @(posedge clk) begin
        if (rst) wr_q <= 1'b0;
        else     wr_q <= wr_i;
    end

    assign fire_o = wr_i & ~wr_q;

    AST_FIRE_NOT_REPEATED: assert property (@(posedge clk) disable iff (rst)
        fire_o |=> !fire_o); // R6

endmodule

// File: rtl/tone_chan_bank.sv
module tone_chan_bank
    import tone_prog_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fire_i,
    input  logic             valid_i,
    input  logic [SEL_W-1:0] sel_i,
    input  chan_cfg_t        cfg_i,
    output chan_cfg_t        cfg_o [NUM_CH],
    output logic [NUM_CH-1:0] upd_o
);

    chan_cfg_t cfg_q [NUM_CH];

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic wen;
        assign wen = fire_i & valid_i & (sel_i == SEL_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[i] <= '0;
                upd_o[i] <= 1'b0;
            end else begin
                upd_o[i] <= wen;
                if (wen) cfg_q[i] <= cfg_i;
            end
        end

        assign cfg_o[i] = cfg_q[i];

        AST_LANE_HOLDS_WITHOUT_UPDATE: assert property (@(posedge clk) disable iff (rst)
            !upd_o[i] |-> $stable(cfg_q[i])); // R3
    end

    AST_SINGLE_LANE_UPDATE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(upd_o)); // R3

endmodule

// File: rtl/tone_prog_top.sv
module tone_prog_top
    import tone_prog_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NOTE_W-1:0]         note_i,
    input  logic [OCT_W-1:0]          oct_i,
    input  logic [LVL_W-1:0]          lvl_i,
    input  logic [SEL_W-1:0]          chan_sel_i,
    input  logic                      wr_i,
    output logic [NUM_CH*CNT_W-1:0]   count_o,
    output logic [NUM_CH*OCT_W-1:0]   oct_o,
    output logic [NUM_CH*LVL_W-1:0]   lvl_o,
    output logic [NUM_CH-1:0]         upd_o
);

    lut_out_t  lut;
    logic      fire;
    chan_cfg_t new_cfg;
    chan_cfg_t cfg [NUM_CH];

    tone_note_lut u_lut (
        .note_i (note_i),
        .lut_o  (lut)
    );

    tone_wr_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .wr_i   (wr_i),
        .fire_o (fire)
    );

    always_comb begin
        new_cfg.count  = lut.count;
        new_cfg.octave = oct_i;
        new_cfg.level  = level_e'(lvl_i);
    end

    tone_chan_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .fire_i  (fire),
        .valid_i (lut.valid),
        .sel_i   (chan_sel_i),
        .cfg_i   (new_cfg),
        .cfg_o   (cfg),
        .upd_o   (upd_o)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_out
        assign count_o[i*CNT_W +: CNT_W] = cfg[i].count;
        assign oct_o[i*OCT_W +: OCT_W]   = cfg[i].octave;
        assign lvl_o[i*LVL_W +: LVL_W]   = cfg[i].level;

        AST_LEVEL_CAPTURED: assert property (@(posedge clk) disable iff (rst)
            upd_o[i] |-> (lvl_o[i*LVL_W +: LVL_W] == $past(lvl_i))); // R4
        AST_COUNT_NONZERO: assert property (@(posedge clk) disable iff (rst)
            upd_o[i] |-> (count_o[i*CNT_W +: CNT_W] != '0)); // R2
    end

    AST_INVALID_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (fire && !lut.valid) |=> (upd_o == '0)); // R5
    AST_UPDATE_NEEDS_FIRE: assert property (@(posedge clk) disable iff (rst)
        (upd_o != '0) |-> $past(fire)); // R7

endmodule

// File: tb/tone_prog_top_bench.sv
module tone_prog_top_bench;

    typedef struct packed {
        logic [31:0] cnt;
        logic [7:0]  oct;
        logic [7:0]  lvl;
        logic [3:0]  upd;
    } snap_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  note_i = '0;
    logic [1:0]  oct_i = '0;
    logic [1:0]  lvl_i = '0;
    logic [1:0]  chan_sel_i = '0;
    logic        wr_i = 1'b0;
    logic [31:0] count_o;
    logic [7:0]  oct_o;
    logic [7:0]  lvl_o;
    logic [3:0]  upd_o;

    int total = 0;
    int fails = 0;
    snap_t exp_q[$];
    logic [31:0] m_cnt = '0;
    logic [7:0]  m_oct = '0;
    logic [7:0]  m_lvl = '0;

    always #5 clk = ~clk;

    tone_prog_top u_tone_prog_top (
        .clk(clk), .rst(rst), .note_i(note_i), .oct_i(oct_i), .lvl_i(lvl_i),
        .chan_sel_i(chan_sel_i), .wr_i(wr_i), .count_o(count_o),
        .oct_o(oct_o), .lvl_o(lvl_o), .upd_o(upd_o)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected count from the note's top-octave pitch: semitone s above C,
    // f = 880 * 2^((s-9)/12), count = round(60000 / f).
    function automatic logic [7:0] ref_count(input int code);
        real f;
        int  s;
        s = 11 - code;
        f = 880.0 * (2.0 ** ((s - 9) / 12.0));
        return 8'($rtoi(60000.0 / f + 0.5));
    endfunction

    // Monitor: every update pulse must match the next queued snapshot.
    always @(negedge clk) begin
        if (!rst && (upd_o != 4'b0)) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 unexpected update", {count_o, oct_o, lvl_o, upd_o}, '0);
            end else begin
                snap_t e;
                e = exp_q.pop_front();
                check({count_o, oct_o, lvl_o, upd_o} == e, "R2/R3/R4/R7 update",
                      {count_o, oct_o, lvl_o, upd_o}, e);
            end
        end
    end

    task automatic do_write(input int note, input int oct, input int lvl, input int ch, input int hold);
        @(negedge clk);
        if (note < 12) begin
            m_cnt[ch*8 +: 8] = ref_count(note);
            m_oct[ch*2 +: 2] = 2'(oct);
            m_lvl[ch*2 +: 2] = 2'(lvl);
            exp_q.push_back({m_cnt, m_oct, m_lvl, 4'(1 << ch)});
        end
        note_i = 4'(note); oct_i = 2'(oct); lvl_i = 2'(lvl); chan_sel_i = 2'(ch);
        wr_i = 1'b1;
        for (int k = 1; k < hold; k++) begin
            @(negedge clk);
            chan_sel_i = chan_sel_i + 2'd1;
            note_i = 4'((note + 3) % 12);
        end
        @(negedge clk);
        wr_i = 1'b0;
    endtask

    task automatic check_state(input string req);
        @(negedge clk);
        @(negedge clk);
        check({count_o, oct_o, lvl_o} == {m_cnt, m_oct, m_lvl}, req,
              {count_o, oct_o, lvl_o}, {m_cnt, m_oct, m_lvl});
        check(upd_o == 4'b0, req, upd_o, 0);
    endtask

    initial begin
        #2000000;
        check(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset state
        check({count_o, oct_o, lvl_o, upd_o} == '0, "R1 during reset", {count_o, oct_o, lvl_o, upd_o}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check({count_o, oct_o, lvl_o, upd_o} == '0, "R1 after reset", {count_o, oct_o, lvl_o, upd_o}, 0);

        // R2, R3, R4, R7: every note code across all lanes, octaves and levels
        for (int n = 0; n < 12; n++) begin
            do_write(n, n % 3, (n + 1) % 4, n % 4, 1);
            check_state("R2 table/R3 lane");
        end

        // R2 explicit spot values
        check(ref_count(0) == 8'd61 && ref_count(2) == 8'd68 && ref_count(11) == 8'd115,
              "R2 reference values", {ref_count(0), ref_count(2), ref_count(11)}, {8'd61, 8'd68, 8'd115});

        // R5: invalid codes rising with the strobe
        for (int n = 12; n < 16; n++) begin
            do_write(n, 3, 3, n % 4, 1);
            check_state("R5 invalid ignored");
        end

        // R6: held strobe with changing select and note
        do_write(4, 1, 2, 2, 5);
        check_state("R6 held strobe");

        // R6/R7: back-to-back writes with one idle cycle
        do_write(9, 2, 3, 0, 1);
        do_write(1, 0, 1, 3, 1);
        check_state("R7 back-to-back");

        // R4: level off written into a lane
        do_write(7, 0, 0, 1, 1);
        check_state("R4 level off stored");

        check(exp_q.size() == 0, "R7 all updates seen", exp_q.size(), 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule